// File: doc/BRIEF.md
# Sector error bit corrector

This block applies already-decoded error locations to one page of flash that has been split into several fixed-size sectors, each followed by its own group of check bytes. Once a read has finished and the root finder has produced, for every sector flagged as faulty, a root count and a list of bit locations, this block walks the flagged sectors and flips each reported bit. It reaches the data buffer and the check-byte buffer through byte-wide read-modify-write ports.

Before it decodes anything, the block reads every check byte of the page. If all of them hold 0xFF, the page is taken to be erased and is left untouched. A sector whose root count differs from its locator degree is declared uncorrectable and ends the page. A location that points past the sector's protected span is treated as a fatal decoder fault.

Each flagged sector is fed over a valid/ready stream. The first beat is a header carrying the root count on the location bus and the locator degree on a separate field. It is followed by exactly degree location beats, each one a 1-based bit position within the sector's span.

Top module: `sec_corr`

## Requirements
- R1: The check bytes per sector equal ceil(m*t/8), with m = 12 + SECT_BYTES/512 and t = T_CAP. The defaults (512-byte sectors, t=8) give 13 bytes per sector and 52 per page, and sector s owns check-buffer indices s*13 to s*13+12.
- R2: When start_i is accepted, all check bytes are read. If every one is 0xFF, the run ends with erased_o=1, no buffer write, no stream beat accepted and corr_cnt_o=0. A single byte other than 0xFF disables this bypass.
- R3: Sectors are served in ascending index order, and only those whose bit is set in sect_stat_i (bit i = sector i). Each served sector consumes one header beat followed by its location beats.
- R4: A location L selects pos = L-1, the byte (pos/8) and the bit (pos%8) within the sector span.
- R5: A byte offset below SECT_BYTES inverts that bit of data byte sector*SECT_BYTES + offset.
- R6: A byte offset from SECT_BYTES to SECT_BYTES+ECC_BPS-1 inverts that bit of check byte sector*ECC_BPS + (offset - SECT_BYTES).
- R7: If the root count in a header differs from its degree, uncorr_o is set, fail_cnt_o increments and the run ends. No write is made and no further beat is accepted.
- R8: A location of 0, or one whose byte offset is SECT_BYTES+ECC_BPS or more, sets fatal_o and ends the run with no write.
- R9: corr_cnt_o is cleared at start and adds the degree of every accepted header.
- R10: done_o is a one-cycle pulse that ends every run, and busy_o drops right after it. A start_i pulse while busy has no effect.
- R11: After reset, busy_o, done_o, loc_ready_o, erased_o, uncorr_o, fatal_o, corr_cnt_o and fail_cnt_o are all zero.
- R12: Each bit correction reads one byte and writes it back on the next cycle, changing only the addressed bit and no other byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a page run |
| sect_stat_i | input | N_SECT | Faulty-sector bitmap, sampled at start |
| loc_valid_i | input | 1 | Stream beat valid |
| loc_ready_o | output | 1 | Stream beat accepted |
| loc_data_i | input | LOC_W | Root count (header) or 1-based bit location |
| loc_deg_i | input | CNT_W | Locator degree (header beat only) |
| dat_addr_o | output | DAT_AW | Data buffer byte address |
| dat_rd_o | output | 1 | Data buffer read strobe |
| dat_rdata_i | input | 8 | Data buffer read byte, one cycle after strobe |
| dat_wr_o | output | 1 | Data buffer write strobe |
| dat_wdata_o | output | 8 | Data buffer write byte |
| ecc_addr_o | output | ECC_AW | Check buffer byte address |
| ecc_rd_o | output | 1 | Check buffer read strobe |
| ecc_rdata_i | input | 8 | Check buffer read byte, one cycle after strobe |
| ecc_wr_o | output | 1 | Check buffer write strobe |
| ecc_wdata_o | output | 8 | Check buffer write byte |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Run finished (pulse) |
| erased_o | output | 1 | Last run found an erased page |
| uncorr_o | output | 1 | Last run hit an uncorrectable sector |
| fatal_o | output | 1 | Last run hit an out-of-span location |
| corr_cnt_o | output | CORR_W | Bits corrected in last run |
| fail_cnt_o | output | FAIL_W | Uncorrectable sectors since reset |

## Verification
The assertions assume that both buffers return read data exactly one cycle after the strobe, and that no other agent writes the buffers during a run. They also assume that a header degree never exceeds T_CAP, so the write-after-read and range properties hold only under that contract. The bench's buffer models have the one-cycle latency and are loaded only while the block is idle. Every header it sends carries a degree of 2 or less.

// File: rtl/sec_corr_pkg.sv
package sec_corr_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_CHK_RD, S_CHK_CMP, S_SCAN, S_HDR, S_LOC, S_FLIP, S_FIN
  } state_t;

  function automatic int ecc_bytes(int sect_bytes, int t_cap);
    return ((12 + sect_bytes / 512) * t_cap + 7) / 8;
  endfunction
endpackage

// File: rtl/sec_corr_loc_dec.sv
module sec_corr_loc_dec #(
  parameter int SECT_BYTES = 512,
  parameter int ECC_BPS    = 13,
  parameter int LOC_W      = 14,
  parameter int SW         = 3,
  parameter int DAT_AW     = 11,
  parameter int ECC_AW     = 6
) (
  input  logic [LOC_W-1:0]  loc_i,
  input  logic [SW-1:0]     sect_i,
  output logic              bad_o,
  output logic              in_data_o,
  output logic [DAT_AW-1:0] dat_addr_o,
  output logic [ECC_AW-1:0] ecc_addr_o,
  output logic [2:0]        bit_o
);
  localparam int BW   = LOC_W - 3;
  localparam int SPAN = SECT_BYTES + ECC_BPS;

  logic [LOC_W-1:0] pos;
  logic [BW-1:0]    byte_w;
  logic [BW-1:0]    off_w;

  assign pos    = loc_i - 1'b1;
  assign byte_w = pos[LOC_W-1:3];
  assign off_w  = byte_w - BW'(SECT_BYTES);
  assign bit_o  = pos[2:0];

  assign bad_o      = (loc_i == '0) || (byte_w >= BW'(SPAN));
  assign in_data_o  = byte_w < BW'(SECT_BYTES);
  assign dat_addr_o = DAT_AW'(sect_i) * DAT_AW'(SECT_BYTES) + DAT_AW'(byte_w);
  assign ecc_addr_o = ECC_AW'(sect_i) * ECC_AW'(ECC_BPS) + ECC_AW'(off_w);
endmodule

// File: rtl/sec_corr_pick.sv
module sec_corr_pick #(
  parameter int N_SECT = 4,
  parameter int SW     = 3
) (
  input  logic [N_SECT-1:0] stat_i,
  input  logic [SW-1:0]     from_i,
  output logic              found_o,
  output logic [SW-1:0]     idx_o
);
  logic [N_SECT-1:0] elig;

  for (genvar gi = 0; gi < N_SECT; gi++) begin : g_elig
    assign elig[gi] = stat_i[gi] && (SW'(gi) >= from_i);
  end

  // lowest eligible sector wins
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N_SECT - 1; i >= 0; i--) begin
      if (elig[i]) begin
        found_o = 1'b1;
        idx_o   = SW'(i);
      end
    end
  end
endmodule

// File: rtl/sec_corr_rmw.sv
module sec_corr_rmw #(
  parameter int AW = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  logic [AW-1:0] addr_i,
  input  logic [2:0]    bit_i,
  input  logic [7:0]    rdata_i,
  output logic [AW-1:0] addr_o,
  output logic          rd_o,
  output logic          wr_o,
  output logic [7:0]    wdata_o,
  output logic          done_o
);
  logic wr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wr_q <= 1'b0;
    else         wr_q <= go_i;
  end

  assign addr_o  = addr_i;
  assign rd_o    = go_i;
  assign wr_o    = wr_q;
  assign done_o  = wr_q;
  assign wdata_o = rdata_i ^ (8'd1 << bit_i);
endmodule

// File: rtl/sec_corr.sv
module sec_corr
  import sec_corr_pkg::*;
#(
  parameter int SECT_BYTES = 512,
  parameter int N_SECT     = 4,
  parameter int T_CAP      = 8,
  parameter int FAIL_W     = 8,
  localparam int ECC_BPS   = ecc_bytes(SECT_BYTES, T_CAP),
  localparam int PAGE_ECC  = N_SECT * ECC_BPS,
  localparam int DAT_AW    = $clog2(N_SECT * SECT_BYTES),
  localparam int ECC_AW    = $clog2(PAGE_ECC),
  localparam int LOC_W     = $clog2((SECT_BYTES + ECC_BPS) * 8 + 1) + 1,
  localparam int CNT_W     = $clog2(T_CAP + 1),
  localparam int CORR_W    = $clog2(N_SECT * T_CAP + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [N_SECT-1:0] sect_stat_i,
  input  logic              loc_valid_i,
  output logic              loc_ready_o,
  input  logic [LOC_W-1:0]  loc_data_i,
  input  logic [CNT_W-1:0]  loc_deg_i,
  output logic [DAT_AW-1:0] dat_addr_o,
  output logic              dat_rd_o,
  input  logic [7:0]        dat_rdata_i,
  output logic              dat_wr_o,
  output logic [7:0]        dat_wdata_o,
  output logic [ECC_AW-1:0] ecc_addr_o,
  output logic              ecc_rd_o,
  input  logic [7:0]        ecc_rdata_i,
  output logic              ecc_wr_o,
  output logic [7:0]        ecc_wdata_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              erased_o,
  output logic              uncorr_o,
  output logic              fatal_o,
  output logic [CORR_W-1:0] corr_cnt_o,
  output logic [FAIL_W-1:0] fail_cnt_o
);
  localparam int SW = $clog2(N_SECT + 1);

  state_t              state_q;
  logic [N_SECT-1:0]   stat_q;
  logic [SW-1:0]       nxt_q, cur_q;
  logic [ECC_AW-1:0]   chk_q;
  logic [CNT_W-1:0]    cnt_q;
  logic                to_ecc_q, go_q;
  logic [DAT_AW-1:0]   dat_addr_q;
  logic [ECC_AW-1:0]   ecc_addr_q;
  logic [2:0]          bit_q;
  logic                erased_q, uncorr_q, fatal_q;
  logic [CORR_W-1:0]   corr_q;
  logic [FAIL_W-1:0]   fail_q;

  logic                dec_bad, dec_in_data;
  logic [DAT_AW-1:0]   dec_dat_addr;
  logic [ECC_AW-1:0]   dec_ecc_addr;
  logic [2:0]          dec_bit;
  logic                pick_found;
  logic [SW-1:0]       pick_idx;
  logic                dat_done, ecc_done, flip_done;
  logic                rmw_ecc_rd;
  logic [ECC_AW-1:0]   rmw_ecc_addr;
  logic                beat;

  sec_corr_loc_dec #(
    .SECT_BYTES(SECT_BYTES), .ECC_BPS(ECC_BPS), .LOC_W(LOC_W),
    .SW(SW), .DAT_AW(DAT_AW), .ECC_AW(ECC_AW)
  ) u_dec (
    .loc_i(loc_data_i), .sect_i(cur_q), .bad_o(dec_bad),
    .in_data_o(dec_in_data), .dat_addr_o(dec_dat_addr),
    .ecc_addr_o(dec_ecc_addr), .bit_o(dec_bit)
  );

  sec_corr_pick #(.N_SECT(N_SECT), .SW(SW)) u_pick (
    .stat_i(stat_q), .from_i(nxt_q), .found_o(pick_found), .idx_o(pick_idx)
  );

  sec_corr_rmw #(.AW(DAT_AW)) u_rmw_dat (
    .clk_i(clk_i), .rst_ni(rst_ni), .go_i(go_q && !to_ecc_q),
    .addr_i(dat_addr_q), .bit_i(bit_q), .rdata_i(dat_rdata_i),
    .addr_o(dat_addr_o), .rd_o(dat_rd_o), .wr_o(dat_wr_o),
    .wdata_o(dat_wdata_o), .done_o(dat_done)
  );

  sec_corr_rmw #(.AW(ECC_AW)) u_rmw_ecc (
    .clk_i(clk_i), .rst_ni(rst_ni), .go_i(go_q && to_ecc_q),
    .addr_i(ecc_addr_q), .bit_i(bit_q), .rdata_i(ecc_rdata_i),
    .addr_o(rmw_ecc_addr), .rd_o(rmw_ecc_rd), .wr_o(ecc_wr_o),
    .wdata_o(ecc_wdata_o), .done_o(ecc_done)
  );

  assign flip_done   = dat_done || ecc_done;
  assign loc_ready_o = (state_q == S_HDR) || (state_q == S_LOC);
  assign beat        = loc_ready_o && loc_valid_i;
  assign ecc_rd_o    = (state_q == S_CHK_RD) || rmw_ecc_rd;
  assign ecc_addr_o  = (state_q == S_CHK_RD) ? chk_q : rmw_ecc_addr;
  assign busy_o      = state_q != S_IDLE;
  assign done_o      = state_q == S_FIN;
  assign erased_o    = erased_q;
  assign uncorr_o    = uncorr_q;
  assign fatal_o     = fatal_q;
  assign corr_cnt_o  = corr_q;
  assign fail_cnt_o  = fail_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      stat_q     <= '0;
      nxt_q      <= '0;
      cur_q      <= '0;
      chk_q      <= '0;
      cnt_q      <= '0;
      to_ecc_q   <= 1'b0;
      go_q       <= 1'b0;
      dat_addr_q <= '0;
      ecc_addr_q <= '0;
      bit_q      <= '0;
      erased_q   <= 1'b0;
      uncorr_q   <= 1'b0;
      fatal_q    <= 1'b0;
      corr_q     <= '0;
      fail_q     <= '0;
    end else begin
      go_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (start_i) begin
          stat_q   <= sect_stat_i;
          nxt_q    <= '0;
          chk_q    <= '0;
          erased_q <= 1'b0;
          uncorr_q <= 1'b0;
          fatal_q  <= 1'b0;
          corr_q   <= '0;
          state_q  <= S_CHK_RD;
        end
        S_CHK_RD: state_q <= S_CHK_CMP;
        S_CHK_CMP: begin
          if (ecc_rdata_i != 8'hFF) begin
            state_q <= S_SCAN;
          end else if (chk_q == ECC_AW'(PAGE_ECC - 1)) begin
            erased_q <= 1'b1;
            state_q  <= S_FIN;
          end else begin
            chk_q   <= chk_q + 1'b1;
            state_q <= S_CHK_RD;
          end
        end
        S_SCAN: begin
          if (pick_found) begin
            cur_q   <= pick_idx;
            nxt_q   <= pick_idx + 1'b1;
            state_q <= S_HDR;
          end else begin
            state_q <= S_FIN;
          end
        end
        S_HDR: if (beat) begin
          if (loc_data_i != LOC_W'(loc_deg_i)) begin
            uncorr_q <= 1'b1;
            fail_q   <= fail_q + 1'b1;
            state_q  <= S_FIN;
          end else begin
            corr_q  <= corr_q + CORR_W'(loc_deg_i);
            cnt_q   <= loc_deg_i;
            state_q <= (loc_deg_i == '0) ? S_SCAN : S_LOC;
          end
        end
        S_LOC: if (beat) begin
          if (dec_bad) begin
            fatal_q <= 1'b1;
            state_q <= S_FIN;
          end else begin
            to_ecc_q   <= !dec_in_data;
            dat_addr_q <= dec_dat_addr;
            ecc_addr_q <= dec_ecc_addr;
            bit_q      <= dec_bit;
            go_q       <= 1'b1;
            state_q    <= S_FLIP;
          end
        end
        S_FLIP: if (flip_done) begin
          cnt_q   <= cnt_q - 1'b1;
          state_q <= (cnt_q == CNT_W'(1)) ? S_SCAN : S_LOC;
        end
        S_FIN:   state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sec_corr_chk.sv
module sec_corr_chk #(
  parameter int CORR_W   = 6,
  parameter int ECC_AW   = 6,
  parameter int PAGE_ECC = 52
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              done_o,
  input logic              loc_ready_o,
  input logic              dat_rd_o,
  input logic              dat_wr_o,
  input logic              ecc_rd_o,
  input logic              ecc_wr_o,
  input logic [ECC_AW-1:0] ecc_addr_o,
  input logic              erased_o,
  input logic              uncorr_o,
  input logic              fatal_o,
  input logic [CORR_W-1:0] corr_cnt_o
);
  a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r10_busy_ends_on_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(done_o));
  a_r12_dat_write_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dat_wr_o |-> $past(dat_rd_o));
  a_r12_ecc_write_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ecc_wr_o |-> $past(ecc_rd_o));
  a_r12_one_buffer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dat_wr_o && ecc_wr_o));
  a_r2_erased_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erased_o |-> (!dat_wr_o && !ecc_wr_o && corr_cnt_o == '0));
  a_r7_r8_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(uncorr_o && fatal_o));
  a_r7_stops_stream: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uncorr_o |-> !loc_ready_o);
  a_r8_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fatal_o |-> (!dat_wr_o && !ecc_wr_o));
  a_r6_ecc_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ecc_wr_o |-> (ecc_addr_o < ECC_AW'(PAGE_ECC)));
  a_r3_ready_when_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loc_ready_o |-> busy_o);
endmodule

bind sec_corr sec_corr_chk #(
  .CORR_W(CORR_W), .ECC_AW(ECC_AW), .PAGE_ECC(PAGE_ECC)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy_o), .done_o(done_o),
  .loc_ready_o(loc_ready_o), .dat_rd_o(dat_rd_o), .dat_wr_o(dat_wr_o),
  .ecc_rd_o(ecc_rd_o), .ecc_wr_o(ecc_wr_o), .ecc_addr_o(ecc_addr_o),
  .erased_o(erased_o), .uncorr_o(uncorr_o), .fatal_o(fatal_o),
  .corr_cnt_o(corr_cnt_o)
);

// File: tb/sec_corr_test.sv
`timescale 1ns/1ps
module sec_corr_test;
  localparam int NS = 4, SB = 512, EB = 13, PE = 52, DB = NS * SB;
  localparam int NV = 7;
  localparam int V_SECT [NV] = '{0, 0, 1, 2, 3, 3, 2};
  localparam int V_LOC  [NV] = '{1, 4096, 4097, 100, 4200, 2050, 4150};
  localparam int V_ECC  [NV] = '{0, 0, 1, 0, 1, 0, 1};
  localparam int V_IDX  [NV] = '{0, 511, 13, 1036, 51, 1792, 32};
  localparam int V_BIT  [NV] = '{0, 7, 0, 3, 7, 1, 5};

  logic clk = 0, rst_n = 0, start = 0;
  logic [3:0] stat = 0;
  logic loc_valid = 0, loc_ready;
  logic [13:0] loc_data = 0;
  logic [3:0] loc_deg = 0;
  logic [10:0] dat_addr; logic dat_rd, dat_wr; logic [7:0] dat_rdata, dat_wdata;
  logic [5:0] ecc_addr;  logic ecc_rd, ecc_wr; logic [7:0] ecc_rdata, ecc_wdata;
  logic busy, done, erased, uncorr, fatal;
  logic [5:0] corr; logic [7:0] fails;

  always #2 clk = ~clk;

  sec_corr uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .sect_stat_i(stat),
    .loc_valid_i(loc_valid), .loc_ready_o(loc_ready), .loc_data_i(loc_data),
    .loc_deg_i(loc_deg), .dat_addr_o(dat_addr), .dat_rd_o(dat_rd),
    .dat_rdata_i(dat_rdata), .dat_wr_o(dat_wr), .dat_wdata_o(dat_wdata),
    .ecc_addr_o(ecc_addr), .ecc_rd_o(ecc_rd), .ecc_rdata_i(ecc_rdata),
    .ecc_wr_o(ecc_wr), .ecc_wdata_o(ecc_wdata), .busy_o(busy), .done_o(done),
    .erased_o(erased), .uncorr_o(uncorr), .fatal_o(fatal),
    .corr_cnt_o(corr), .fail_cnt_o(fails)
  );

  logic [7:0] dmem [DB];
  logic [7:0] emem [PE];
  logic init_req = 0; int emode = 0;
  logic clr = 0;
  int hs_cnt, wr_cnt, done_cnt, rdy_seen;
  int n_chk = 0, n_err = 0;
  int e_ecc [4], e_idx [4], e_bit [4]; int n_e = 0;

  function automatic logic [7:0] dpat(int i); return 8'(i * 7 + 3); endfunction
  function automatic logic [7:0] epat(int i, int m);
    if (m == 1) return 8'hFF;
    if (m == 2) return (i == PE - 1) ? 8'h00 : 8'hFF;
    return 8'(i);
  endfunction

  always @(posedge clk) begin
    if (init_req) begin
      for (int i = 0; i < DB; i++) dmem[i] <= dpat(i);
      for (int i = 0; i < PE; i++) emem[i] <= epat(i, emode);
    end else begin
      if (dat_rd) dat_rdata <= dmem[dat_addr];
      if (dat_wr) dmem[dat_addr] <= dat_wdata;
      if (ecc_rd) ecc_rdata <= emem[ecc_addr];
      if (ecc_wr) emem[ecc_addr] <= ecc_wdata;
    end
  end

  always @(posedge clk) begin
    if (clr) begin hs_cnt <= 0; wr_cnt <= 0; done_cnt <= 0; rdy_seen <= 0; end
    else begin
      if (loc_valid && loc_ready) hs_cnt <= hs_cnt + 1;
      if (dat_wr || ecc_wr) wr_cnt <= wr_cnt + 1;
      if (done) done_cnt <= done_cnt + 1;
      if (loc_ready) rdy_seen <= 1;
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load(int m);
    @(negedge clk); init_req = 1; emode = m;
    @(negedge clk); init_req = 0;
    n_e = 0;
  endtask

  task automatic go(logic [3:0] s);
    @(negedge clk); clr = 1;
    @(negedge clk); clr = 0; start = 1; stat = s;
    @(negedge clk); start = 0;
  endtask

  task automatic send(int d, int g);
    @(negedge clk); loc_valid = 1; loc_data = 14'(d); loc_deg = 4'(g);
    while (!loc_ready) @(negedge clk);
    @(posedge clk); #1 loc_valid = 0;
  endtask

  task automatic wait_done();
    int k = 0;
    while (done_cnt == 0 && k < 3000) begin @(negedge clk); k++; end
    chk(done_cnt == 1 && !busy, "R10 done pulse", done_cnt, 1);
  endtask

  task automatic mem_check(string req);
    int mism = 0;
    for (int i = 0; i < DB; i++) begin
      logic [7:0] v = dpat(i);
      for (int k = 0; k < n_e; k++) if (!e_ecc[k] && e_idx[k] == i) v ^= 8'(1 << e_bit[k]);
      if (dmem[i] !== v) mism++;
    end
    for (int i = 0; i < PE; i++) begin
      logic [7:0] v = epat(i, emode);
      for (int k = 0; k < n_e; k++) if (e_ecc[k] && e_idx[k] == i) v ^= 8'(1 << e_bit[k]);
      if (emem[i] !== v) mism++;
    end
    chk(mism == 0, req, mism, 0);
  endtask

  task automatic add_exp(int is_ecc, int idx, int b);
    e_ecc[n_e] = is_ecc; e_idx[n_e] = idx; e_bit[n_e] = b; n_e++;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    #(4 * 150000);
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(!busy && !done && !loc_ready && !erased && !uncorr && !fatal,
        "R11 flags at reset", {busy, done, loc_ready, erased, uncorr, fatal}, 0);
    chk(corr == 0 && fails == 0, "R11 counters at reset", corr + fails, 0);
    rst_n = 1;
    @(negedge clk);

    // multi-sector run: sectors 1 and 3, start pulse while busy ignored (R3, R10)
    load(0);
    go(4'b1010);
    @(negedge clk); start = 1; stat = 4'b0000;
    @(negedge clk); start = 0;
    send(2, 2); send(9, 0); send(4104, 0);
    send(1, 1); send(16, 0);
    wait_done();
    add_exp(0, 513, 0); add_exp(1, 13, 7); add_exp(0, 1537, 7);
    mem_check("R3 ascending flagged sectors");
    chk(corr == 3, "R9 sum of degrees", corr, 3);
    chk(hs_cnt == 5, "R3 beats consumed", hs_cnt, 5);

    // table of single-location vectors: R1 R4 R5 R6 R9 R12
    for (int v = 0; v < NV; v++) begin
      load(0);
      go(4'(1 << V_SECT[v]));
      send(1, 1); send(V_LOC[v], 0);
      wait_done();
      add_exp(V_ECC[v], V_IDX[v], V_BIT[v]);
      mem_check(V_ECC[v] ? "R6 R1 R4 check-byte flip" : "R5 R4 data flip");
      chk(corr == 1, "R9 cleared at start", corr, 1);
      chk(wr_cnt == 1, "R12 single write", wr_cnt, 1);
    end

    // R2 erased page
    load(1);
    go(4'b1111);
    wait_done();
    chk(erased == 1, "R2 erased flag", erased, 1);
    chk(wr_cnt == 0 && rdy_seen == 0, "R2 no write no beat", wr_cnt + rdy_seen, 0);
    chk(corr == 0, "R2 no count", corr, 0);
    mem_check("R2 buffers untouched");

    // R2 one non-FF check byte
    load(2);
    go(4'b0001);
    send(0, 0);
    wait_done();
    chk(erased == 0 && hs_cnt == 1, "R2 not erased", erased, 0);

    // empty bitmap and degree-zero sector: R3
    load(0);
    go(4'b0000);
    wait_done();
    chk(rdy_seen == 0 && wr_cnt == 0, "R3 no sector served", rdy_seen + wr_cnt, 0);
    go(4'b0001);
    send(0, 0);
    wait_done();
    chk(wr_cnt == 0 && corr == 0 && hs_cnt == 1, "R3 degree zero", wr_cnt + corr, 0);

    // R7 uncorrectable
    load(0);
    go(4'b0011);
    send(1, 2);
    wait_done();
    chk(uncorr == 1 && fatal == 0, "R7 uncorrectable flag", uncorr, 1);
    chk(fails == 1, "R7 failure counter", fails, 1);
    chk(hs_cnt == 1 && wr_cnt == 0, "R7 stops run", hs_cnt + wr_cnt, 1);
    mem_check("R7 buffers untouched");

    // R8 beyond span and zero location
    go(4'b0001);
    send(1, 1); send(4201, 0);
    wait_done();
    chk(fatal == 1 && wr_cnt == 0, "R8 beyond span", fatal, 1);
    go(4'b0100);
    send(1, 1); send(0, 0);
    wait_done();
    chk(fatal == 1 && wr_cnt == 0 && uncorr == 0, "R8 zero location", fatal, 1);
    mem_check("R8 buffers untouched");
    chk(fails == 1, "R7 counter kept", fails, 1);

    summary();
    $finish;
  end
endmodule